// File: doc/BRIEF.md
# Serial-Frame Parallel I/O Port

The block drives and reads back a small group of open-drain general-purpose pins that belong to a framed serial audio link. Each pin has an output latch: a 0 in the latch turns on the pulldown and holds the pin low. A 1 releases the pin, so an external pull-up, or another device, sets its level. To use a pin as an input, software leaves a 1 in its latch and then reads the level back.

The port runs in one of two modes, chosen by a mode input. In data mode the latches are loaded, and the pin levels captured, on each rising edge of the frame sync. The serial bit clock plays no part in this mode. A level captured in one frame is presented for shifting out during the following frame. In control mode the latches cannot be changed, and the pins are only observed. The first rising edge of the bit clock after a frame sync rising edge captures the pin levels. That value is presented within the same frame.

Frame sync and bit clock are produced synchronously to the master clock `clk`, and their rising edges are detected in that domain. The pad levels are asynchronous, so each passes through a two-stage synchronizer before it is used.

Top module: `sfpio_top`

## Requirements
- R1: After reset every bit of `pad_rel` is 1 (all pins released) and `rd_bits` is 0.
- R2: In data mode (`data_mode`=1), a rising edge of `fsync` loads `wr_data` into the latches. The new value shows on `pad_rel` one `clk` cycle after the edge, where bit value 0 means pulled low and 1 means released.
- R3: Pad levels reach the capture logic through two synchronizing flops. A `pad_in` change made only one `clk` cycle before the capturing edge is not captured; the earlier level is captured instead.
- R4: In data mode, the pin levels captured at frame k's `fsync` rising edge appear on `rd_bits` one cycle after frame k+1's rising edge. They stay there until the next frame edge.
- R5: In data mode, edges of `sclk` change neither `pad_rel` nor `rd_bits`.
- R6: In control mode (`data_mode`=0), `fsync` edges and any `wr_data` value leave `pad_rel` unchanged.
- R7: In control mode, the first `sclk` rising edge after an `fsync` rising edge captures the pin levels into `rd_bits`, visible one cycle later in the same frame. Further `sclk` edges in that frame, and any `sclk` edge before the first frame edge after reset, leave `rd_bits` unchanged.
- R8: A pin whose latch holds 0 reads back as 0 whatever the external level. A released pin reads back the external level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, synchronous to clk |
| sclk | input | 1 | Serial bit clock, synchronous to clk |
| data_mode | input | 1 | 1 = data mode, 0 = control mode |
| wr_data | input | PINS | Values for the output latches, used in data mode |
| pad_in | input | PINS | Pad input levels, asynchronous |
| pad_rel | output | PINS | Per pin: 0 turns the pulldown on, 1 releases the pin |
| rd_bits | output | PINS | Read-back levels for the outgoing serial stream |

## Verification
Every combination of latch value and external level on the two pins is swept in data mode. This separates a driven-low pin from a released pin that an outside device holds low or leaves high, and it shows the one-frame read-back delay from frame to frame. A pad change timed one cycle before a frame edge shows the synchronizer depth. Bit-clock bursts in data mode, and frame edges carrying new write data in control mode, show that each mode ignores the other mode's timing source. Repeated bit-clock edges within one control frame, and a bit-clock edge before any frame, show that only the first armed edge samples the pins.

// File: rtl/sfpio_pkg.sv
package sfpio_pkg;
    localparam int unsigned PIO_PINS = 2;
    localparam int unsigned PIO_SYNC = 2;

    typedef enum logic {
        MODE_CTRL = 1'b0,
        MODE_DATA = 1'b1
    } pio_mode_e;
endpackage

// File: rtl/sfpio_sync.sv
module sfpio_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

    // R3: the last stage follows the one before it by exactly one clock
    if (STAGES > 1) begin : g_chk
        p_stage_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> chain_q[STAGES-1] == $past(chain_q[STAGES-2]));
    end
endmodule

// File: rtl/sfpio_edge.sv
module sfpio_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/sfpio_core.sv
module sfpio_core
    import sfpio_pkg::*;
#(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_rise,
    input  logic         bit_rise,
    input  pio_mode_e    mode,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pins_sync,
    output logic [W-1:0] latch,
    output logic [W-1:0] rd_bits
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] hold;
        logic [W-1:0] rd;
        logic         armed;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode == MODE_DATA) begin
            st_d.armed = 1'b0;
            if (frame_rise) begin
                st_d.lat  = wr_data;
                st_d.rd   = st_q.hold;
                st_d.hold = pins_sync;
            end
        end else begin
            if (frame_rise) begin
                st_d.armed = 1'b1;
            end else if (bit_rise && st_q.armed) begin
                st_d.rd    = pins_sync;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat   <= '1;
            st_q.hold  <= '0;
            st_q.rd    <= '0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch   = st_q.lat;
    assign rd_bits = st_q.rd;

    // R2: a data-mode frame edge loads the write value
    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rise && mode == MODE_DATA) |=> latch == $past(wr_data));

    // R6: the latches change only on a data-mode frame edge
    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_rise && mode == MODE_DATA) |=> $stable(latch));

    // R5: outside frame edges, data mode never alters the read-back
    p_data_no_bitclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA && !frame_rise) |=> $stable(rd_bits));

    // R7: an armed control-mode bit edge captures the synchronized pins
    p_ctrl_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTRL && !frame_rise && bit_rise && st_q.armed)
        |=> rd_bits == $past(pins_sync));

    // R7: an unarmed control-mode bit edge is ignored
    p_ctrl_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTRL && !frame_rise && !st_q.armed) |=> $stable(rd_bits));
endmodule

// File: rtl/sfpio_top.sv
module sfpio_top
    import sfpio_pkg::*;
#(
    parameter int unsigned PINS   = PIO_PINS,
    parameter int unsigned STAGES = PIO_SYNC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fsync,
    input  logic            sclk,
    input  logic            data_mode,
    input  logic [PINS-1:0] wr_data,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_rel,
    output logic [PINS-1:0] rd_bits
);
    logic            frame_rise;
    logic            bit_rise;
    logic [PINS-1:0] pins_sync;
    pio_mode_e       mode;

    assign mode = data_mode ? MODE_DATA : MODE_CTRL;

    sfpio_sync #(.W(PINS), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    sfpio_edge u_fedge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fsync),
        .rise  (frame_rise)
    );

    sfpio_edge u_bedge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk),
        .rise  (bit_rise)
    );

    sfpio_core #(.W(PINS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_rise (frame_rise),
        .bit_rise   (bit_rise),
        .mode       (mode),
        .wr_data    (wr_data),
        .pins_sync  (pins_sync),
        .latch      (pad_rel),
        .rd_bits    (rd_bits)
    );
endmodule

// File: tb/sim_sfpio_top.sv
module sim_sfpio_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       sclk = 1'b0;
    logic       data_mode = 1'b1;
    logic [1:0] wr_data = 2'b11;
    logic [1:0] ext = 2'b11;
    logic [1:0] pad_in;
    logic [1:0] pad_rel;
    logic [1:0] rd_bits;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [1:0] m_lat, m_hold, m_rd;
    bit         m_arm;

    assign pad_in = ext & pad_rel;

    always #(CLK_P/2) clk = ~clk;

    sfpio_top u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .sclk(sclk),
        .data_mode(data_mode), .wr_data(wr_data), .pad_in(pad_in),
        .pad_rel(pad_rel), .rd_bits(rd_bits)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_frame();
        logic [1:0] now;
        settle();
        now = ext & m_lat;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        if (data_mode) begin
            m_rd = m_hold; m_hold = now; m_lat = wr_data; m_arm = 1'b0;
        end else begin
            m_arm = 1'b1;
        end
    endtask

    task automatic do_bit();
        logic [1:0] now;
        settle();
        now = ext & m_lat;
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        if (!data_mode && m_arm) begin
            m_rd = now; m_arm = 1'b0;
        end
    endtask

    initial begin
        m_lat = 2'b11; m_hold = 2'b00; m_rd = 2'b00; m_arm = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pad_rel after reset", pad_rel, 2'b11);
        check("R1 rd_bits after reset", rd_bits, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_rel held", pad_rel, 2'b11);

        // R7: bit edge before any frame edge in control mode
        data_mode = 1'b0;
        do_bit();
        check("R7 unarmed bit edge", rd_bits, 2'b00);

        // R2 R4 R8: data-mode sweep of latch and external levels
        data_mode = 1'b1;
        for (int w = 0; w < 4; w++) begin
            for (int e = 0; e < 4; e++) begin
                wr_data = w[1:0];
                ext = e[1:0];
                do_frame();
                check("R2 latch load", pad_rel, m_lat);
                check("R4 one-frame read", rd_bits, m_rd);
                do_frame();
                check("R8 open-drain read", rd_bits, m_rd);
            end
        end

        // R3: change one cycle before the frame edge is missed
        wr_data = 2'b11; ext = 2'b11;
        do_frame(); do_frame(); do_frame();
        check("R3 setup", rd_bits, 2'b11);
        @(negedge clk); ext = 2'b00;
        @(negedge clk); fsync = 1'b1;
        @(negedge clk); fsync = 1'b0;
        m_rd = m_hold; m_hold = 2'b11;
        check("R3 prior read", rd_bits, 2'b11);
        do_frame();
        check("R3 old level captured", rd_bits, 2'b11);
        do_frame();
        check("R3 new level next", rd_bits, 2'b00);

        // R5: bit clock has no effect in data mode
        ext = 2'b10; wr_data = 2'b11;
        do_frame(); do_frame();
        for (int k = 0; k < 6; k++) begin
            wr_data = 2'(k);
            ext = 2'(k + 1);
            do_bit();
            check("R5 pad_rel stable", pad_rel, 2'b11);
            check("R5 rd_bits stable", rd_bits, m_rd);
        end

        // R6: control mode ignores writes
        data_mode = 1'b0;
        ext = 2'b10;
        for (int k = 0; k < 4; k++) begin
            wr_data = 2'(k);
            do_frame();
            check("R6 latch unchanged", pad_rel, 2'b11);
        end

        // R7: first bit edge per frame samples, same frame
        do_bit();
        check("R7 first bit edge", rd_bits, 2'b10);
        ext = 2'b01;
        do_bit();
        check("R7 second bit edge ignored", rd_bits, 2'b10);
        do_frame();
        check("R7 frame alone no sample", rd_bits, 2'b10);
        do_bit();
        check("R7 next frame sample", rd_bits, 2'b01);
        ext = 2'b00;
        do_bit();
        check("R7 repeat ignored", rd_bits, 2'b01);
        do_frame();
        do_bit();
        check("R7 released pins low", rd_bits, 2'b00);

        // R2 R8: back in data mode, drive one pin low
        data_mode = 1'b1;
        ext = 2'b11; wr_data = 2'b01;
        do_frame();
        check("R2 drive high pin low", pad_rel, 2'b01);
        do_frame(); do_frame();
        check("R8 driven pin reads 0", rd_bits, 2'b01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule